// File: doc/BRIEF.md
# Byte-Port DMA Channel Register File

This block holds the software-visible registers of a four-channel DMA controller. Software reaches it through a narrow 8-bit register port. Each channel keeps a 16-bit memory address, a 16-bit transfer count and a 2-bit transfer mode. It also has a mask bit that enables or disables the channel, and a terminal-count status flag.

The 16-bit registers are reached one byte at a time. A single byte-pointer flip-flop picks the low or the high byte and flips after every access. Software clears the pointer with a dedicated command before it starts a 16-bit access.

The transfer engine that sits beside the block presents one transfer cycle at a time on `xfer_req`/`xfer_chan`. It takes the current memory address from `xfer_addr`. On each accepted cycle the block steps that channel: the address goes up by one and the count goes down by one. The count is kept in bus cycles, not in bytes. Software reads the live count back to find out how much of a transfer remains.

Top module: `dmareg_file`

## Requirements
- R1: After synchronous reset every mask bit is 1, every terminal-count flag is 0, the byte pointer selects the low byte, all addresses and counts are 0, and every mode is 0 (idle).
- R2: Port offsets 0..7 reach the 16-bit registers. The channel is offset bits [2:1], and offset bit 0 picks the address (0) or the count (1). The byte pointer picks the low byte (0) or the high byte (1), and it toggles after every read or write at these offsets.
- R3: A write to offset 12, with its data ignored, returns the byte pointer to the low byte.
- R4: A register read returns the current working address or count. A byte write loads that byte of the working register at once. Any write to a channel's count clears that channel's terminal-count flag.
- R5: A write to offset 8 sets the mode of channel wdata[3:2] to wdata[1:0]. The codes are 0 idle, 1 device-to-memory, 2 memory-to-device and 3 cascade. The mode of channel i appears on chan_mode[2i+1:2i].
- R6: A write to offset 9 sets (wdata[2]=1) or clears (wdata[2]=0) the mask of channel wdata[1:0]. A write to offset 10 loads all four masks from wdata[3:0], where 1 means masked. A read of offset 10 returns the masks in bits [3:0]. chan_ready[i] is 1 only when channel i is unmasked and its mode is 1 or 2.
- R7: When xfer_req is 1 for a ready channel xfer_chan, that channel's address rises by one and its count falls by one at the next clock edge. xfer_addr always shows the current address of xfer_chan.
- R8: A transfer cycle aimed at a masked channel, or at one in idle or cascade mode, changes nothing.
- R9: A transfer cycle taken while the count is 0 wraps the count to 0xFFFF and sets that channel's terminal-count flag. A read of offset 8 returns the four flags in bits [3:0].
- R10: A write to offset 13 (master clear) returns the pointer to the low byte, sets all masks and clears all flags. Addresses, counts and modes are kept. A transfer cycle in the same clock is dropped.
- R11: If a byte write to a channel's address or count falls in the same cycle as a transfer cycle on that channel, the written register takes the new byte and keeps its other byte unstepped. The other register of that channel still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register port offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| xfer_req | input | 1 | Transfer cycle taken this clock |
| xfer_chan | input | 2 | Channel of the transfer cycle |
| xfer_addr | output | 16 | Current address of xfer_chan |
| chan_ready | output | 4 | Channel unmasked and in a data-moving mode |
| chan_tc | output | 4 | Terminal-count flags |
| chan_mask | output | 4 | Mask bits |
| chan_mode | output | 8 | Two mode bits per channel |

## Verification
The main concern is a register write landing in the same cycle as a transfer step. A byte write to the address or count of a channel can meet a step on that channel, and a master clear can meet a step. The bench forces each of these overlaps in directed cycles, and random traffic with steps asserted half the time makes them happen often. The outcome is judged by reading back both bytes of both registers and checking the flags. The expected values come from a bench model that applies R10 and R11 as priorities.

// File: rtl/dmareg_pkg.sv
`timescale 1ns/1ps
package dmareg_pkg;

    typedef enum logic [1:0] {
        XM_IDLE     = 2'd0,
        XM_TO_MEM   = 2'd1,
        XM_FROM_MEM = 2'd2,
        XM_CASCADE  = 2'd3
    } xmode_e;

    localparam int unsigned OFS_MODE_STAT = 8;
    localparam int unsigned OFS_MASK_ONE  = 9;
    localparam int unsigned OFS_MASK_ALL  = 10;
    localparam int unsigned OFS_PTR_CLR   = 12;
    localparam int unsigned OFS_MCLR      = 13;

    typedef struct packed {
        logic chreg;
        logic wide;
        logic is_cnt;
        logic mode_wr;
        logic mask_one;
        logic mask_all;
        logic ptr_clr;
        logic mclr;
    } cmd_t;

    function automatic logic moves_data(xmode_e m);
        return (m == XM_TO_MEM) || (m == XM_FROM_MEM);
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
`timescale 1ns/1ps
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int N_CHAN = 4,
    parameter int PA_W   = 4,
    localparam int CH_W  = $clog2(N_CHAN)
) (
    input  logic            wr,
    input  logic            rd,
    input  logic [PA_W-1:0] addr,
    output cmd_t            cmd,
    output logic [CH_W-1:0] ch
);
    localparam int CH_SPAN = 2 * N_CHAN;

    always_comb begin
        cmd        = '0;
        ch         = addr[CH_W:1];
        cmd.is_cnt = addr[0];
        if (addr < PA_W'(CH_SPAN)) begin
            cmd.chreg = 1'b1;
            cmd.wide  = wr | rd;
        end else if (wr) begin
            case (addr)
                PA_W'(OFS_MODE_STAT): cmd.mode_wr  = 1'b1;
                PA_W'(OFS_MASK_ONE):  cmd.mask_one = 1'b1;
                PA_W'(OFS_MASK_ALL):  cmd.mask_all = 1'b1;
                PA_W'(OFS_PTR_CLR):   cmd.ptr_clr  = 1'b1;
                PA_W'(OFS_MCLR):      cmd.mclr     = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmareg_ptr.sv
`timescale 1ns/1ps
module dmareg_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic toggle,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi <= 1'b0;
        end else if (toggle) begin
            hi <= ~hi;
        end
    end
endmodule

// File: rtl/dmareg_chan.sv
`timescale 1ns/1ps
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int REG_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mclr,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_wr,
    input  xmode_e            mode_in,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              step_req,
    output logic [REG_W-1:0]  addr_q,
    output logic [REG_W-1:0]  cnt_q,
    output xmode_e            mode_q,
    output logic              mask_q,
    output logic              tc_q,
    output logic              ready
);
    logic step;

    function automatic logic [REG_W-1:0] put_byte(
        logic [REG_W-1:0] old, logic [DATA_W-1:0] b, logic hi);
        return hi ? {b, old[DATA_W-1:0]} : {old[REG_W-1:DATA_W], b};
    endfunction

    assign ready = ~mask_q & moves_data(mode_q);
    assign step  = step_req & ready & ~mclr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= XM_IDLE;
            mask_q <= 1'b1;
            tc_q   <= 1'b0;
        end else begin
            if (wr_addr) begin
                addr_q <= put_byte(addr_q, wdata, byte_hi);
            end else if (step) begin
                addr_q <= addr_q + REG_W'(1);
            end

            if (wr_cnt) begin
                cnt_q <= put_byte(cnt_q, wdata, byte_hi);
            end else if (step) begin
                cnt_q <= cnt_q - REG_W'(1);
            end

            if (mclr || wr_cnt) begin
                tc_q <= 1'b0;
            end else if (step && (cnt_q == '0)) begin
                tc_q <= 1'b1;
            end

            if (mclr) begin
                mask_q <= 1'b1;
            end else if (mask_wr) begin
                mask_q <= mask_val;
            end

            if (mode_wr) begin
                mode_q <= mode_in;
            end
        end
    end

endmodule

// File: rtl/dmareg_file.sv
`timescale 1ns/1ps
module dmareg_file
    import dmareg_pkg::*;
#(
    parameter int N_CHAN  = 4,
    parameter int DATA_W  = 8,
    parameter int PA_W    = 4,
    localparam int CH_W   = $clog2(N_CHAN),
    localparam int REG_W  = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [PA_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                xfer_req,
    input  logic [CH_W-1:0]     xfer_chan,
    output logic [REG_W-1:0]    xfer_addr,
    output logic [N_CHAN-1:0]   chan_ready,
    output logic [N_CHAN-1:0]   chan_tc,
    output logic [N_CHAN-1:0]   chan_mask,
    output logic [2*N_CHAN-1:0] chan_mode
);
    cmd_t                         cmd;
    logic [CH_W-1:0]              dec_ch;
    logic                         ptr_hi;
    logic [N_CHAN-1:0][REG_W-1:0] addr_q;
    logic [N_CHAN-1:0][REG_W-1:0] cnt_q;
    logic [N_CHAN-1:0]            wr_cnt;
    logic [REG_W-1:0]             rd_word;
    logic                         wr_wide;

    dmareg_decode #(.N_CHAN(N_CHAN), .PA_W(PA_W)) i_decode (
        .wr   (reg_wr),
        .rd   (reg_rd),
        .addr (reg_addr),
        .cmd  (cmd),
        .ch   (dec_ch)
    );

    dmareg_ptr i_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd.ptr_clr | cmd.mclr),
        .toggle (cmd.wide),
        .hi     (ptr_hi)
    );

    assign wr_wide = reg_wr & cmd.wide;

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        logic   sel;
        logic   wr_addr_i;
        logic   mode_wr_i;
        logic   mask_wr_i;
        logic   mask_val_i;
        xmode_e mode_i;

        assign sel        = (dec_ch == CH_W'(i));
        assign wr_addr_i  = wr_wide & sel & ~cmd.is_cnt;
        assign wr_cnt[i]  = wr_wide & sel & cmd.is_cnt;
        assign mode_wr_i  = cmd.mode_wr & (reg_wdata[CH_W+1:2] == CH_W'(i));
        assign mask_wr_i  = cmd.mask_all
                          | (cmd.mask_one & (reg_wdata[CH_W-1:0] == CH_W'(i)));
        assign mask_val_i = cmd.mask_all ? reg_wdata[i] : reg_wdata[CH_W];

        dmareg_chan #(.DATA_W(DATA_W)) i_chan (
            .clk      (clk),
            .rst      (rst),
            .mclr     (cmd.mclr),
            .wr_addr  (wr_addr_i),
            .wr_cnt   (wr_cnt[i]),
            .byte_hi  (ptr_hi),
            .wdata    (reg_wdata),
            .mode_wr  (mode_wr_i),
            .mode_in  (xmode_e'(reg_wdata[1:0])),
            .mask_wr  (mask_wr_i),
            .mask_val (mask_val_i),
            .step_req (xfer_req & (xfer_chan == CH_W'(i))),
            .addr_q   (addr_q[i]),
            .cnt_q    (cnt_q[i]),
            .mode_q   (mode_i),
            .mask_q   (chan_mask[i]),
            .tc_q     (chan_tc[i]),
            .ready    (chan_ready[i])
        );

        assign chan_mode[2*i +: 2] = mode_i;
    end

    assign xfer_addr = addr_q[xfer_chan];
    assign rd_word   = cmd.is_cnt ? cnt_q[dec_ch] : addr_q[dec_ch];

    always_comb begin
        reg_rdata = '0;
        if (cmd.chreg) begin
            reg_rdata = ptr_hi ? rd_word[REG_W-1:DATA_W] : rd_word[DATA_W-1:0];
        end else if (reg_addr == PA_W'(OFS_MODE_STAT)) begin
            reg_rdata = DATA_W'(chan_tc);
        end else if (reg_addr == PA_W'(OFS_MASK_ALL)) begin
            reg_rdata = DATA_W'(chan_mask);
        end
    end

endmodule

// File: rtl/dmareg_chk.sv
`timescale 1ns/1ps
module dmareg_chk #(
    parameter int N_CHAN = 4,
    parameter int REG_W  = 16,
    parameter int CH_W   = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wide,
    input logic                         ptr_clr,
    input logic                         mclr,
    input logic                         ptr_hi,
    input logic                         xfer_req,
    input logic [CH_W-1:0]              xfer_chan,
    input logic [N_CHAN-1:0]            ready,
    input logic [N_CHAN-1:0]            mask,
    input logic [N_CHAN-1:0]            tc,
    input logic [N_CHAN-1:0][REG_W-1:0] cnt,
    input logic                         wr_cnt_any
);
    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        wide |=> (ptr_hi != $past(ptr_hi)));                          // R2

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ptr_clr || mclr) |=> !ptr_hi);                               // R3

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
        mclr |=> ((&mask) && (tc == '0)));                           // R10

    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|(tc & ~$past(tc))) |-> $past(xfer_req));                    // R9

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!(xfer_req && ready[xfer_chan]) && !wr_cnt_any) |=> $stable(cnt)); // R8
endmodule

bind dmareg_file dmareg_chk #(.N_CHAN(N_CHAN), .REG_W(REG_W), .CH_W(CH_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .wide       (cmd.wide),
    .ptr_clr    (cmd.ptr_clr),
    .mclr       (cmd.mclr),
    .ptr_hi     (ptr_hi),
    .xfer_req   (xfer_req),
    .xfer_chan  (xfer_chan),
    .ready      (chan_ready),
    .mask       (chan_mask),
    .tc         (chan_tc),
    .cnt        (cnt_q),
    .wr_cnt_any (|wr_cnt)
);

// File: tb/test_dmareg_file.sv
`timescale 1ns/1ps
module test_dmareg_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, xfer_req = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  xfer_chan = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] xfer_addr;
    logic [3:0]  chan_ready, chan_tc, chan_mask;
    logic [7:0]  chan_mode;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [1:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc;
    bit          m_ptr;
    logic [7:0]  last_rd;

    always #2.5 clk = ~clk;

    dmareg_file i_dmareg_file (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_req(xfer_req), .xfer_chan(xfer_chan), .xfer_addr(xfer_addr),
        .chan_ready(chan_ready), .chan_tc(chan_tc), .chan_mask(chan_mask),
        .chan_mode(chan_mode)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [3:0] a);
        logic [15:0] w;
        if (a < 4'd8) begin
            w = a[0] ? m_cnt[a[2:1]] : m_addr[a[2:1]];
            return m_ptr ? w[15:8] : w[7:0];
        end
        if (a == 4'd8)  return {4'b0, m_tc};
        if (a == 4'd10) return {4'b0, m_mask};
        return 8'h00;
    endfunction

    function automatic logic [3:0] model_ready();
        logic [3:0] r;
        for (int c = 0; c < 4; c++)
            r[c] = !m_mask[c] && (m_mode[c] == 2'd1 || m_mode[c] == 2'd2);
        return r;
    endfunction

    task automatic model_update(input bit w, input bit r, input logic [3:0] a,
                                input logic [7:0] d, input bit xq, input logic [1:0] xc);
        bit         mcl  = w && a == 4'd13;
        bit         wide = (w || r) && a < 4'd8;
        logic [1:0] ch   = a[2:1];
        bit         stp  = xq && model_ready()[xc] && !mcl;
        if (stp) begin
            if (!(w && wide && ch == xc && !a[0])) m_addr[xc] = m_addr[xc] + 16'd1;
            if (!(w && wide && ch == xc && a[0])) begin
                if (m_cnt[xc] == 16'd0) m_tc[xc] = 1'b1;
                m_cnt[xc] = m_cnt[xc] - 16'd1;
            end
        end
        if (w && wide) begin
            if (a[0]) begin
                if (m_ptr) m_cnt[ch][15:8] = d; else m_cnt[ch][7:0] = d;
                m_tc[ch] = 1'b0;
            end else begin
                if (m_ptr) m_addr[ch][15:8] = d; else m_addr[ch][7:0] = d;
            end
        end
        if (w && a == 4'd8)  m_mode[d[3:2]] = d[1:0];
        if (w && a == 4'd9)  m_mask[d[1:0]] = d[2];
        if (w && a == 4'd10) m_mask = d[3:0];
        if (w && a == 4'd12) m_ptr = 1'b0;
        if (mcl) begin
            m_ptr = 1'b0; m_mask = 4'hF; m_tc = 4'h0;
        end
        if (wide) m_ptr = !m_ptr;
    endtask

    task automatic cyc(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d,
                       input bit xq, input logic [1:0] xc);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        xfer_req = xq; xfer_chan = xc;
        #1;
        last_rd = reg_rdata;
        if (r) check("R4 register read", {8'h0, reg_rdata}, {8'h0, model_read(a)});
        if (xq) check("R7 xfer_addr", xfer_addr, m_addr[xc]);
        @(posedge clk);
        model_update(w, r, a, d, xq, xc);
        #1;
        reg_wr = 0; reg_rd = 0; xfer_req = 0;
        check("R6 mask outputs", {12'h0, chan_mask}, {12'h0, m_mask});
        check("R6 ready outputs", {12'h0, chan_ready}, {12'h0, model_ready()});
        check("R9 tc outputs", {12'h0, chan_tc}, {12'h0, m_tc});
        check("R5 mode outputs", {8'h0, chan_mode},
              {8'h0, m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, 2'd0);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc(0, 1, a, 8'h00, 0, 2'd0);
    endtask

    task automatic step(input logic [1:0] c);
        cyc(0, 0, 4'd0, 8'h00, 1, c);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = '0; m_cnt[c] = '0; m_mode[c] = '0;
        end
        m_mask = 4'hF; m_tc = 4'h0; m_ptr = 1'b0;
        void'($urandom(32'h5EED_0D1A));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 masks after reset", {12'h0, chan_mask}, 16'h000F);
        check("R1 tc after reset", {12'h0, chan_tc}, 16'h0000);
        check("R1 modes after reset", {8'h0, chan_mode}, 16'h0000);
        rd(4'd10); check("R1 mask readback", {8'h0, last_rd}, 16'h000F);
        rd(4'd3);  check("R1 count low byte", {8'h0, last_rd}, 16'h0000);
        rd(4'd3);  check("R1 count high byte", {8'h0, last_rd}, 16'h0000);

        // R2 byte-wise access
        wr(4'd2, 8'h34); wr(4'd2, 8'h12);
        rd(4'd2); check("R2 low byte", {8'h0, last_rd}, 16'h0034);
        rd(4'd2); check("R2 high byte", {8'h0, last_rd}, 16'h0012);

        // R3 pointer clear
        wr(4'd3, 8'hAB);
        wr(4'd12, 8'hFF);
        rd(4'd3); check("R3 low byte after clear", {8'h0, last_rd}, 16'h00AB);
        wr(4'd12, 8'h00);

        // R5 mode
        wr(4'd8, 8'h0A);
        check("R5 channel 2 mode", {14'h0, chan_mode[5:4]}, 16'h0002);

        // R6 masks
        wr(4'd9, 8'h02);
        check("R6 single unmask ready", {15'h0, chan_ready[2]}, 16'h0001);
        wr(4'd10, 8'h05);
        check("R6 mask all ready", {12'h0, chan_ready}, 16'h0000);
        rd(4'd10); check("R6 mask readback", {8'h0, last_rd}, 16'h0005);
        wr(4'd10, 8'h0F);

        // R7 stepping
        wr(4'd0, 8'hFF); wr(4'd0, 8'h00);
        wr(4'd1, 8'h01); wr(4'd1, 8'h00);
        wr(4'd8, 8'h01); wr(4'd9, 8'h00);
        step(2'd0);
        rd(4'd0); check("R7 address low", {8'h0, last_rd}, 16'h0000);
        rd(4'd0); check("R7 address high carry", {8'h0, last_rd}, 16'h0001);
        rd(4'd1); check("R7 count low", {8'h0, last_rd}, 16'h0000);
        rd(4'd1);
        check("R7 tc still clear", {12'h0, chan_tc}, 16'h0000);

        // R9 terminal count wrap
        step(2'd0);
        check("R9 tc set on wrap", {15'h0, chan_tc[0]}, 16'h0001);
        rd(4'd8); check("R9 status read", {8'h0, last_rd}, 16'h0001);
        rd(4'd1); check("R9 count low wrapped", {8'h0, last_rd}, 16'h00FF);
        rd(4'd1); check("R9 count high wrapped", {8'h0, last_rd}, 16'h00FF);

        // R8 ignored steps
        wr(4'd9, 8'h04);
        step(2'd0);
        rd(4'd1); check("R8 masked step ignored", {8'h0, last_rd}, 16'h00FF);
        rd(4'd1);
        wr(4'd8, 8'h03); wr(4'd9, 8'h00);
        step(2'd0);
        rd(4'd0); check("R8 cascade step ignored", {8'h0, last_rd}, 16'h0001);
        rd(4'd0);

        // R4 count write clears tc
        wr(4'd1, 8'h05); wr(4'd1, 8'h00);
        check("R4 count write clears tc", {12'h0, chan_tc}, 16'h0000);
        wr(4'd8, 8'h01);

        // R11 write colliding with a step
        cyc(1, 0, 4'd1, 8'h20, 1, 2'd0);
        wr(4'd12, 8'h00);
        rd(4'd1); check("R11 written count low", {8'h0, last_rd}, 16'h0020);
        rd(4'd1); check("R11 count high unstepped", {8'h0, last_rd}, 16'h0000);
        rd(4'd0); check("R11 address still steps", {8'h0, last_rd}, 16'h0002);
        rd(4'd0);

        // R10 master clear with a step in the same clock
        rd(4'd0);
        cyc(1, 0, 4'd13, 8'h00, 1, 2'd0);
        check("R10 all masked", {12'h0, chan_mask}, 16'h000F);
        rd(4'd1); check("R10 pointer low, count kept", {8'h0, last_rd}, 16'h0020);
        rd(4'd1);
        check("R10 mode kept", {14'h0, chan_mode[1:0]}, 16'h0001);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned op = $urandom % 8;
            logic [3:0]  a  = 4'($urandom % 16);
            logic [7:0]  d  = ($urandom % 2) ? 8'($urandom % 4) : 8'($urandom);
            bit          xq = ($urandom % 2) == 1;
            logic [1:0]  xc = 2'($urandom % 4);
            if (a == 4'd13 && ($urandom % 4) != 0) a = 4'd9;
            if (a == 4'd9) d[2] = ($urandom % 4) == 0;
            if (op < 3)      cyc(1, 0, a, d, xq, xc);
            else if (op < 6) cyc(0, 1, a, d, xq, xc);
            else             cyc(0, 0, a, d, xq, xc);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule